// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Claim and Complete

This block gathers level-sensitive interrupt lines and presents one interrupt request per context, such as one per processor privilege target. Software programs a priority for each source, an enable bitmap and a priority threshold for each context. It then services interrupts through a claim/complete register. Each source id equals its input bit index. Id 0 is reserved to mean "nothing to service", so input 0 never becomes pending.

Each context has its own arbiter. The arbiter picks, among sources that are pending, enabled for that context and not already claimed, the one with the highest priority strictly above the context threshold. Ties go to the lower id.

A read of the claim register returns that winner. In the same cycle it moves the winner from pending to claimed, so no context can hand it out again. Writing the id back completes the interrupt and releases the source. If the source line is still high, the source becomes pending again.

Priority and threshold writes follow a write-any-read-legal rule. The rule depends on whether the maximum priority plus one is a power of two.

Top module: `intc_core`

## Requirements
- R1: While `rst` is high, and after it falls, all priorities, thresholds, enables, pending bits and claimed bits read 0, and `irq_o` is all zeros.
- R2: Every cycle with `bus_valid_i` high gets exactly one response cycle on the next clock, with `rsp_valid_o` high. Write responses carry data 0. An access whose address bits [1:0] are not zero returns error 1 and data 0, and changes nothing.
- R3: The priority of source n is read and written at `PRIO_BASE + 4*n`, for n from 0 to `NUM_SRC-1`. The stored value occupies bits [PRIO_W-1:0] of the word.
- R4: With maximum priority N and N+1 a power of two, a written priority or threshold value v is stored as v mod (N+1). Otherwise, writes with v > N are dropped without error and the old value is kept.
- R5: Pending word w sits at `PEND_BASE + 4*w`, and its bit i reports source 32*w+i. Each pending bit follows its source line one clock later, and bit 0 always reads 0. Writes there return error 1 and change nothing.
- R6: Enable word w of context c sits at `EN_BASE + c*EN_STRIDE + 4*w`, and its bit i enables source 32*w+i. A word index at or above ceil(NUM_SRC/32) returns error 1 and data 0, and is not written.
- R7: In context c's window at `CTX_BASE + c*CTX_STRIDE`, offset 0 is the threshold and offset 4 is claim/complete. Any other offset returns error 1 and data 0.
- R8: The winner of a context is the source with the highest priority strictly above the threshold among sources that are pending, enabled and unclaimed. Equal priorities go to the lowest id. The winner is 0 when no source qualifies.
- R9: A claim read returns the current winner id. When the id is nonzero, the source's pending bit clears and its claimed bit sets on the same clock edge. A claimed source is excluded from every context until it is completed.
- R10: Writing id k to claim/complete clears the claimed bit of source k when k < NUM_SRC. Otherwise the write is ignored without error. A completed source whose line is still high is pending again.
- R11: `irq_o[c]` is a register. It is high one clock after context c's winner becomes nonzero, and low one clock after the winner returns to 0.
- R12: Addresses outside every window read 0 with error 1, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Level interrupt lines, bit index = source id |
| bus_valid_i | input | 1 | Access request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response for the previous cycle's access |
| rsp_data_o | output | 32 | Read data (0 for writes and errors) |
| rsp_err_o | output | 1 | Access was invalid or to a read-only region |
| irq_o | output | NUM_CTX | Per-context interrupt request |

## Verification
Several properties are checked on every cycle:
- one response follows each request;
- error responses carry zero data;
- reset silences the outputs;
- a claim leaves its source claimed and not pending on the next cycle;
- the arbiter never hands out an already-claimed source.

Other behaviour depends on programmed state and can only be shown by bench scenarios. This covers which id wins under thresholds and ties, the modulo-versus-discard priority legalisation in the two parameter variants, and re-pending of a still-high line after completion. It also covers the rejection of pending writes, bad enable words and bad context offsets.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // True when a window [base, base+span) contains addr.
  function automatic logic in_window(input logic [31:0] addr,
                                     input logic [31:0] base,
                                     input logic [31:0] span);
    return (addr >= base) && ((addr - base) < span);
  endfunction

  // Legality of a priority/threshold write for a given maximum priority.
  // With max+1 a power of two every value is accepted and the low bits kept.
  function automatic logic prio_write_ok(input logic [31:0] value,
                                         input int unsigned max_prio);
    if (((max_prio + 1) & max_prio) == 0) return 1'b1;
    return value <= max_prio;
  endfunction

endpackage

// File: rtl/intc_gateway.sv
module intc_gateway #(
  parameter int NUM_SRC = 40,
  parameter int ID_W    = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               take_vld_i,
  input  logic [ID_W-1:0]    take_id_i,
  input  logic               done_vld_i,
  input  logic [ID_W-1:0]    done_id_i,
  output logic [NUM_SRC-1:0] pending_o,
  output logic [NUM_SRC-1:0] claimed_o
);

  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] clm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      clm_q  <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (i == 0) begin
          pend_q[i] <= 1'b0;
          clm_q[i]  <= 1'b0;
        end else begin
          // level follows the line; a claim drops it for one cycle
          pend_q[i] <= src_i[i] & ~(take_vld_i && (take_id_i == ID_W'(i)));
          if (take_vld_i && (take_id_i == ID_W'(i)))
            clm_q[i] <= 1'b1;
          else if (done_vld_i && (done_id_i == ID_W'(i)))
            clm_q[i] <= 1'b0;
        end
      end
    end
  end

  assign pending_o = pend_q;
  assign claimed_o = clm_q;

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NUM_SRC = 40,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 6
) (
  input  logic [NUM_SRC-1:0]             cand_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]              thr_i,
  output logic [ID_W-1:0]                win_o
);

  logic [PRIO_W-1:0] best_p;

  // Linear scan: strict compare keeps the lowest id on ties.
  always_comb begin
    best_p = thr_i;
    win_o  = '0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (cand_i[i] && (prio_i[i] > best_p)) begin
        best_p = prio_i[i];
        win_o  = ID_W'(i);
      end
    end
  end

endmodule

// File: rtl/intc_core.sv
module intc_core #(
  parameter int          NUM_SRC    = 40,
  parameter int          NUM_CTX    = 2,
  parameter int          MAX_PRIO   = 7,
  parameter int          ADDR_W     = 24,
  parameter logic [31:0] PRIO_BASE  = 32'h0000_0000,
  parameter logic [31:0] PEND_BASE  = 32'h0000_1000,
  parameter logic [31:0] EN_BASE    = 32'h0000_2000,
  parameter logic [31:0] EN_STRIDE  = 32'h0000_0080,
  parameter logic [31:0] CTX_BASE   = 32'h0020_0000,
  parameter logic [31:0] CTX_STRIDE = 32'h0000_1000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_valid_i,
  input  logic               bus_write_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic               rsp_valid_o,
  output logic [31:0]        rsp_data_o,
  output logic               rsp_err_o,
  output logic [NUM_CTX-1:0] irq_o
);
  import intc_pkg::*;

  localparam int PRIO_W   = $clog2(MAX_PRIO + 1);
  localparam int ID_W     = $clog2(NUM_SRC);
  localparam int EN_WORDS = (NUM_SRC + 31) / 32;
  localparam int EW_W     = (EN_WORDS > 1) ? $clog2(EN_WORDS) : 1;
  localparam int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam int EN_SH    = $clog2(EN_STRIDE);
  localparam int CTX_SH   = $clog2(CTX_STRIDE);
  localparam logic [31:0] PRIO_SPAN = 32'(NUM_SRC * 4);
  localparam logic [31:0] PEND_SPAN = 32'(EN_WORDS * 4);
  localparam logic [31:0] EN_SPAN   = 32'(NUM_CTX) * EN_STRIDE;
  localparam logic [31:0] CTX_SPAN  = 32'(NUM_CTX) * CTX_STRIDE;

  // ---------------- architectural state ----------------
  logic [NUM_SRC-1:0][PRIO_W-1:0]          prio_q;
  logic [NUM_CTX-1:0][PRIO_W-1:0]          thr_q;
  logic [NUM_CTX-1:0][EN_WORDS*32-1:0]     en_q;
  logic [NUM_CTX-1:0]                      irq_q;
  logic                                    rsp_valid_q;
  logic [31:0]                             rsp_data_q;
  logic                                    rsp_err_q;

  logic [NUM_SRC-1:0]                      pending_w;
  logic [NUM_SRC-1:0]                      claimed_w;
  logic [NUM_CTX-1:0][ID_W-1:0]            win;
  logic [EN_WORDS*32-1:0]                  pend_flat;

  // ---------------- address decode ----------------
  logic [31:0]       addr32;
  logic              aligned;
  logic [31:0]       off_prio, off_pend, off_en, off_ctx;
  logic              hit_prio, hit_pend, hit_en, hit_ctx;
  logic [ID_W-1:0]   prio_idx;
  logic [EW_W-1:0]   pend_word;
  logic [CTX_W-1:0]  en_ctx, ctx_idx;
  logic [31:0]       en_word_full, ctx_off;
  logic [EW_W-1:0]   en_word;
  logic              en_word_ok, is_thr, is_clm;
  logic              rd, wr, prio_ok;

  always_comb begin
    addr32       = 32'(bus_addr_i);
    aligned      = (addr32 & 32'h3) == 32'h0;
    off_prio     = addr32 - PRIO_BASE;
    off_pend     = addr32 - PEND_BASE;
    off_en       = addr32 - EN_BASE;
    off_ctx      = addr32 - CTX_BASE;
    hit_prio     = aligned && in_window(addr32, PRIO_BASE, PRIO_SPAN);
    hit_pend     = aligned && in_window(addr32, PEND_BASE, PEND_SPAN);
    hit_en       = aligned && in_window(addr32, EN_BASE, EN_SPAN);
    hit_ctx      = aligned && in_window(addr32, CTX_BASE, CTX_SPAN);
    prio_idx     = ID_W'(off_prio >> 2);
    pend_word    = EW_W'(off_pend >> 2);
    en_ctx       = CTX_W'(off_en >> EN_SH);
    en_word_full = (off_en & (EN_STRIDE - 32'd1)) >> 2;
    en_word_ok   = en_word_full < 32'(EN_WORDS);
    en_word      = EW_W'(en_word_full);
    ctx_idx      = CTX_W'(off_ctx >> CTX_SH);
    ctx_off      = off_ctx & (CTX_STRIDE - 32'd1);
    is_thr       = ctx_off == 32'd0;
    is_clm       = ctx_off == 32'd4;
    rd           = bus_valid_i && !bus_write_i;
    wr           = bus_valid_i && bus_write_i;
    prio_ok      = prio_write_ok(bus_wdata_i, MAX_PRIO);
  end

  // ---------------- claim / complete side effects ----------------
  logic            take_vld, done_vld;
  logic [ID_W-1:0] take_id, done_id;

  assign take_id  = win[ctx_idx];
  assign take_vld = rd && hit_ctx && is_clm && (take_id != '0);
  assign done_vld = wr && hit_ctx && is_clm && (bus_wdata_i < 32'(NUM_SRC));
  assign done_id  = ID_W'(bus_wdata_i);

  intc_gateway #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .src_i      (src_i),
    .take_vld_i (take_vld),
    .take_id_i  (take_id),
    .done_vld_i (done_vld),
    .done_id_i  (done_id),
    .pending_o  (pending_w),
    .claimed_o  (claimed_w)
  );

  assign pend_flat = (EN_WORDS*32)'(pending_w);

  // ---------------- per-context arbitration ----------------
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    logic [NUM_SRC-1:0] cand;
    assign cand = pending_w & ~claimed_w & en_q[c][NUM_SRC-1:0];
    intc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .cand_i (cand),
      .prio_i (prio_q),
      .thr_i  (thr_q[c]),
      .win_o  (win[c])
    );
  end

  // ---------------- read mux ----------------
  logic [31:0] rdata_n;
  logic        err_n;

  always_comb begin
    rdata_n = '0;
    err_n   = 1'b0;
    if (hit_prio) begin
      rdata_n = 32'(prio_q[prio_idx]);
    end else if (hit_pend) begin
      rdata_n = pend_flat[pend_word*32 +: 32];
      err_n   = bus_write_i;
    end else if (hit_en) begin
      if (en_word_ok) rdata_n = en_q[en_ctx][en_word*32 +: 32];
      else            err_n   = 1'b1;
    end else if (hit_ctx) begin
      if (is_thr)      rdata_n = 32'(thr_q[ctx_idx]);
      else if (is_clm) rdata_n = 32'(take_id);
      else             err_n   = 1'b1;
    end else begin
      err_n = 1'b1;
    end
  end

  // ---------------- register updates ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q      <= '0;
      thr_q       <= '0;
      en_q        <= '0;
      irq_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      rsp_err_q   <= 1'b0;
    end else begin
      rsp_valid_q <= bus_valid_i;
      rsp_err_q   <= bus_valid_i && err_n;
      rsp_data_q  <= (rd && !err_n) ? rdata_n : 32'h0;
      if (wr && hit_prio && prio_ok)
        prio_q[prio_idx] <= bus_wdata_i[PRIO_W-1:0];
      if (wr && hit_en && en_word_ok)
        en_q[en_ctx][en_word*32 +: 32] <= bus_wdata_i;
      if (wr && hit_ctx && is_thr && prio_ok)
        thr_q[ctx_idx] <= bus_wdata_i[PRIO_W-1:0];
      for (int c = 0; c < NUM_CTX; c++)
        irq_q[c] <= win[c] != '0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign rsp_err_o   = rsp_err_q;
  assign irq_o       = irq_q;

endmodule

// File: rtl/intc_core_chk.sv
module intc_core_chk #(
  parameter int NUM_SRC = 40,
  parameter int NUM_CTX = 2,
  parameter int ID_W    = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_valid,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic [31:0]        rsp_data,
  input logic [NUM_CTX-1:0] irq,
  input logic               take_vld,
  input logic [ID_W-1:0]    take_id,
  input logic [NUM_SRC-1:0] pending,
  input logic [NUM_SRC-1:0] claimed
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (irq == '0) && !rsp_valid);

  assert_one_rsp_R2: assert property (@(posedge clk) disable iff (rst)
    bus_valid |=> rsp_valid);

  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> !rsp_valid);

  assert_err_data_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_data == 32'h0));

  assert_claim_moves_R9: assert property (@(posedge clk) disable iff (rst)
    take_vld |=> (claimed[$past(take_id)] && !pending[$past(take_id)]));

  assert_claim_unclaimed_R9: assert property (@(posedge clk) disable iff (rst)
    take_vld |-> !claimed[take_id]);

endmodule

bind intc_core intc_core_chk #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .ID_W(ID_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_valid (bus_valid_i),
  .rsp_valid (rsp_valid_o),
  .rsp_err   (rsp_err_o),
  .rsp_data  (rsp_data_o),
  .irq       (irq_o),
  .take_vld  (take_vld),
  .take_id   (take_id),
  .pending   (pending_w),
  .claimed   (claimed_w)
);

// File: tb/intc_core_tb_top.sv
`timescale 1ns/1ps
module intc_core_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  // main instance (max priority 7: modulo legalisation)
  logic [39:0] a_src = '0;
  logic        a_v = 1'b0, a_w = 1'b0;
  logic [23:0] a_a = '0;
  logic [31:0] a_d = '0;
  logic        a_rv, a_re;
  logic [31:0] a_rd;
  logic [1:0]  a_irq;

  // second instance (max priority 5: discard legalisation)
  logic [7:0]  b_src = '0;
  logic        b_v = 1'b0, b_w = 1'b0;
  logic [23:0] b_a = '0;
  logic [31:0] b_d = '0;
  logic        b_rv, b_re;
  logic [31:0] b_rd;
  logic [0:0]  b_irq;

  intc_core dut_i (
    .clk(clk), .rst(rst), .src_i(a_src),
    .bus_valid_i(a_v), .bus_write_i(a_w), .bus_addr_i(a_a), .bus_wdata_i(a_d),
    .rsp_valid_o(a_rv), .rsp_data_o(a_rd), .rsp_err_o(a_re), .irq_o(a_irq));

  intc_core #(.NUM_SRC(8), .NUM_CTX(1), .MAX_PRIO(5)) dut_b_i (
    .clk(clk), .rst(rst), .src_i(b_src),
    .bus_valid_i(b_v), .bus_write_i(b_w), .bus_addr_i(b_a), .bus_wdata_i(b_d),
    .rsp_valid_o(b_rv), .rsp_data_o(b_rd), .rsp_err_o(b_re), .irq_o(b_irq));

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct packed { logic sel; logic [31:0] d; logic e; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  // address helpers
  function automatic logic [23:0] prio_a(int n); return 24'(4*n); endfunction
  function automatic logic [23:0] pend_a(int w); return 24'(32'h1000 + 4*w); endfunction
  function automatic logic [23:0] en_a(int c, int w); return 24'(32'h2000 + 32'h80*c + 4*w); endfunction
  function automatic logic [23:0] thr_a(int c); return 24'(32'h20_0000 + 32'h1000*c); endfunction
  function automatic logic [23:0] clm_a(int c); return 24'(32'h20_0004 + 32'h1000*c); endfunction

  // driver: one access, expected response queued for the monitor
  task automatic op(input bit sel, input bit w, input logic [23:0] a, input logic [31:0] d,
                    input logic [31:0] ed, input bit ee, input string tag);
    @(negedge clk);
    exp_q.push_back('{sel: sel, d: ed, e: ee});
    tag_q.push_back(tag);
    if (!sel) begin a_v = 1'b1; a_w = w; a_a = a; a_d = d; end
    else      begin b_v = 1'b1; b_w = w; b_a = a; b_d = d; end
    @(negedge clk);
    a_v = 1'b0; b_v = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a, input logic [31:0] ed, input bit ee, input string tag);
    op(1'b0, 1'b0, a, 32'h0, ed, ee, tag);
  endtask
  task automatic wr(input logic [23:0] a, input logic [31:0] d, input bit ee, input string tag);
    op(1'b0, 1'b1, a, d, 32'h0, ee, tag);
  endtask

  task automatic chk_irq(input logic [1:0] exp, input string tag);
    checks++;
    if (a_irq !== exp) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b", tag, a_irq, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // monitor: compares each response against the head of the queue
  always @(negedge clk) begin
    if (a_rv || b_rv) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected response data %h expected none", a_rv ? a_rd : b_rd);
      end else begin
        exp_t  e;
        string t;
        logic [31:0] ad;
        logic        ae, av;
        e  = exp_q.pop_front();
        t  = tag_q.pop_front();
        av = e.sel ? b_rv : a_rv;
        ad = e.sel ? b_rd : a_rd;
        ae = e.sel ? b_re : a_re;
        if (!av || ad !== e.d || ae !== e.e) begin
          errors++;
          $display("FAIL %s data %h err %0d expected data %h err %0d", t, ad, ae, e.d, e.e);
        end
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk_irq(2'b00, "R1");
    rd(prio_a(5), 32'h0, 1'b0, "R1");
    rd(pend_a(0), 32'h0, 1'b0, "R1");
    rd(thr_a(1), 32'h0, 1'b0, "R1");
    rd(en_a(1, 1), 32'h0, 1'b0, "R1");
    rd(clm_a(0), 32'h0, 1'b0, "R1");

    // R3 / R4 priorities, modulo legalisation
    wr(prio_a(3), 32'd5, 1'b0, "R3");
    rd(prio_a(3), 32'd5, 1'b0, "R3");
    wr(prio_a(7), 32'd9, 1'b0, "R4");
    rd(prio_a(7), 32'd1, 1'b0, "R4");
    wr(prio_a(35), 32'd6, 1'b0, "R3");
    rd(prio_a(39), 32'd0, 1'b0, "R3");
    rd(prio_a(40), 32'd0, 1'b1, "R12");

    // R5 pending mirrors lines, source 0 never pending, read-only
    a_src[0] = 1'b1; a_src[3] = 1'b1; a_src[35] = 1'b1;
    settle();
    rd(pend_a(0), 32'h8, 1'b0, "R5");
    rd(pend_a(1), 32'h8, 1'b0, "R5");
    wr(pend_a(0), 32'hFFFF_FFFF, 1'b1, "R5");
    rd(pend_a(0), 32'h8, 1'b0, "R5");
    chk_irq(2'b00, "R8 nothing enabled");

    // R6 enables, R11 latency
    wr(en_a(0, 0), 32'h88, 1'b0, "R6");
    chk_irq(2'b00, "R11 one cycle latency");
    @(negedge clk);
    chk_irq(2'b01, "R11");
    wr(en_a(0, 1), 32'h8, 1'b0, "R6");
    rd(en_a(0, 0), 32'h88, 1'b0, "R6");
    rd(en_a(0, 1), 32'h8, 1'b0, "R6");
    wr(en_a(0, 2), 32'hFFFF_FFFF, 1'b1, "R6");
    rd(en_a(0, 2), 32'h0, 1'b1, "R6");

    // R8 / R9 claims in priority order
    rd(clm_a(0), 32'd35, 1'b0, "R9");
    rd(clm_a(0), 32'd3, 1'b0, "R9");
    rd(clm_a(0), 32'd0, 1'b0, "R9");
    settle();
    chk_irq(2'b00, "R11 after claims");

    // R10 out-of-range complete ignored
    wr(clm_a(0), 32'd40, 1'b0, "R10");
    rd(clm_a(0), 32'd0, 1'b0, "R10");
    wr(clm_a(0), 32'd35, 1'b0, "R10");

    // R7 / R8 threshold is strict
    wr(thr_a(0), 32'd6, 1'b0, "R7");
    rd(thr_a(0), 32'd6, 1'b0, "R7");
    settle();
    chk_irq(2'b00, "R8 threshold");
    rd(clm_a(0), 32'd0, 1'b0, "R8");
    wr(thr_a(0), 32'd5, 1'b0, "R7");
    rd(clm_a(0), 32'd35, 1'b0, "R8");
    wr(thr_a(0), 32'd12, 1'b0, "R4");
    rd(thr_a(0), 32'd4, 1'b0, "R4");
    wr(thr_a(0), 32'd0, 1'b0, "R7");

    // R8 tie goes to lowest id on context 1
    wr(prio_a(9), 32'd4, 1'b0, "R8");
    wr(prio_a(12), 32'd4, 1'b0, "R8");
    wr(en_a(1, 0), 32'h1200, 1'b0, "R8");
    a_src[9] = 1'b1; a_src[12] = 1'b1;
    settle();
    chk_irq(2'b10, "R8 ctx1");
    rd(clm_a(1), 32'd9, 1'b0, "R8");
    rd(clm_a(1), 32'd12, 1'b0, "R8");
    rd(clm_a(1), 32'd0, 1'b0, "R9");

    // R5 line drop clears pending; R10 re-pend of still-high line
    a_src[35] = 1'b0;
    settle();
    rd(pend_a(1), 32'h0, 1'b0, "R5");
    wr(clm_a(0), 32'd35, 1'b0, "R10");
    rd(clm_a(0), 32'd0, 1'b0, "R5");
    wr(clm_a(0), 32'd3, 1'b0, "R10");
    rd(clm_a(0), 32'd3, 1'b0, "R10");

    // R7 / R12 / R2 invalid accesses
    rd(thr_a(0) + 24'd8, 32'h0, 1'b1, "R7");
    wr(thr_a(0) + 24'd8, 32'd1, 1'b1, "R7");
    rd(24'h10_0000, 32'h0, 1'b1, "R12");
    wr(24'h10_0000, 32'd1, 1'b1, "R12");
    wr(24'h000006, 32'd3, 1'b1, "R2");
    rd(prio_a(1), 32'h0, 1'b0, "R2");
    rd(24'h000005, 32'h0, 1'b1, "R2");

    // R4 discard legalisation on the second instance
    op(1'b1, 1'b1, prio_a(1), 32'd3, 32'h0, 1'b0, "R4");
    op(1'b1, 1'b1, prio_a(1), 32'd6, 32'h0, 1'b0, "R4");
    op(1'b1, 1'b0, prio_a(1), 32'h0, 32'd3, 1'b0, "R4");
    op(1'b1, 1'b1, prio_a(1), 32'd5, 32'h0, 1'b0, "R4");
    op(1'b1, 1'b0, prio_a(1), 32'h0, 32'd5, 1'b0, "R4");
    op(1'b1, 1'b1, thr_a(0), 32'd7, 32'h0, 1'b0, "R4");
    op(1'b1, 1'b0, thr_a(0), 32'h0, 32'd0, 1'b0, "R4");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 missing responses actual %0d expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule